// File: doc/BRIEF.md
# Reload-Floor Multi-Channel PWM Timer

This block produces several pulse-width-modulated outputs that share one period. An 8-bit up-counter runs from a programmable floor value up to 255. On the count after 255 it jumps back to the floor. The period is therefore set by where the counter restarts, not by a top value, and the output frequency is the count rate divided by (256 − floor). All channels change to their first state at the restart. Each channel has its own compare value, which sets where the second edge falls.

Software reaches the block through a simple register port that offers single-cycle writes and reads with one cycle of latency. Through this port it programs:

- the floor value;
- four compare values;
- per-channel polarity and output-enable bits;
- a global run bit.

New compare and floor values are staged and only take effect at the next restart, so a period in progress is never disturbed. Each restart sets a sticky overflow flag, and that flag drives the interrupt output. Reading the control register clears the flag. The counter advances only on cycles where the external count-enable input is high and the run bit is set.

Top module: `rfpwm_timer`

## Requirements
- R1: Once restarted, the counter runs from the active floor value up to 255 and then reloads the floor. With count-enable held high and the run bit set, the period is (256 − floor) clock cycles on every channel.
- R2: Within one period, a channel stays in its first state while the counter is at or below its active compare value. This lasts (compare + 1 − floor) cycles. It spends the remaining (255 − compare) cycles in the opposite state.
- R3: A compare value below the floor holds the channel permanently in the second state. A compare value of 255 holds it permanently in the first state.
- R4: A write to a compare register goes to a staging copy. The channel only uses the new value from the next restart on, so the running period finishes with the old value.
- R5: A write to the floor register takes effect only at the next restart.
- R6: Polarity bit 0 gives a high first state. Polarity bit 1 gives a low first state.
- R7: When a channel's output-enable bit is 0, its output is held at the second-state level, which is the value of its polarity bit.
- R8: Every restart sets the overflow flag, which is bit 7 of the control register, and `irq_o` mirrors that flag. A read of the control register returns the flag and then clears it, unless a restart happens in the same cycle.
- R9: The counter holds its value on any cycle where `cnt_en_i` is low or run bit 0 of the control register is 0, and the outputs do not change.
- R10: After reset the following all read as zero: the counter, the floor, the compare registers, polarity, enables, the run bit and the flag. All outputs are then low.
- R11: The register map is as follows:
  - address 0: control, with bit 0 the run bit and bit 7 the flag;
  - address 1: floor;
  - address 2: polarity, in bits 3:0;
  - address 3: output enable, in bits 3:0;
  - addresses 4 to 7: compare values for channels 0 to 3, where a read returns the staged value.

  The read data appears one cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Count enable qualifier for the counter |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| pwm_o | output | 4 | Per-channel PWM outputs (registered) |
| irq_o | output | 1 | Overflow interrupt (level, follows flag) |

## Verification
The main function is exercised with a middle compare value at floor 6 and again at floor 56, and with a compare value below the floor and one at 255. Measuring the high and low run lengths of a single period separates a correct compare rule from off-by-one variants, and a correct period from a wrong wrap value. Inverted polarity on one channel shows whether the first-state level is taken from the right bit. A compare value written just after a falling edge, with the length of the remaining low run measured, shows whether staging is honoured. Freezing the counter through either the count-enable input or the run bit, and holding an output for longer than any segment, shows that counting is gated.

// File: rtl/rfpwm_pkg.sv
package rfpwm_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_FLOOR  = 1;
  localparam int REG_POL    = 2;
  localparam int REG_OE     = 3;
  localparam int REG_CMP0   = 4;
  localparam int FLAG_BIT   = 7;
endpackage

// File: rtl/rfpwm_regs.sv
module rfpwm_regs #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          wrap_i,
  output logic [CNT_W-1:0]              rd_data_o,
  output logic                          run_o,
  output logic [CNT_W-1:0]              floor_stage_o,
  output logic [NUM_CH-1:0]             pol_o,
  output logic [NUM_CH-1:0]             oe_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_stage_o,
  output logic                          flag_o
);
  import rfpwm_pkg::*;

  localparam int AI_W = ADDR_W + 1;

  logic [AI_W-1:0] addr_ext;
  logic            sel_ctrl;
  logic            unused_wdata;

  assign addr_ext     = {1'b0, addr_i};
  assign sel_ctrl     = (int'(addr_ext) == REG_CTRL);
  assign unused_wdata = ^wr_data_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_o         <= 1'b0;
      floor_stage_o <= '0;
      pol_o         <= '0;
      oe_o          <= '0;
    end else if (wr_en_i) begin
      if (sel_ctrl)                           run_o         <= wr_data_i[0];
      if (int'(addr_ext) == REG_FLOOR)        floor_stage_o <= wr_data_i;
      if (int'(addr_ext) == REG_POL)          pol_o         <= wr_data_i[NUM_CH-1:0];
      if (int'(addr_ext) == REG_OE)           oe_o          <= wr_data_i[NUM_CH-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    always_ff @(posedge clk_i) begin
      if (rst_i)
        cmp_stage_o[c] <= '0;
      else if (wr_en_i && int'(addr_ext) == REG_CMP0 + c)
        cmp_stage_o[c] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      flag_o <= 1'b0;
    else if (wrap_i)
      flag_o <= 1'b1;
    else if (rd_en_i && sel_ctrl)
      flag_o <= 1'b0;
  end

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[0]        = run_o;
      rd_mux[FLAG_BIT] = flag_o;
    end else if (int'(addr_ext) == REG_FLOOR) begin
      rd_mux = floor_stage_o;
    end else if (int'(addr_ext) == REG_POL) begin
      rd_mux[NUM_CH-1:0] = pol_o;
    end else if (int'(addr_ext) == REG_OE) begin
      rd_mux[NUM_CH-1:0] = oe_o;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (int'(addr_ext) == REG_CMP0 + c) rd_mux = cmp_stage_o[c];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_i |=> flag_o);
endmodule

// File: rtl/rfpwm_counter.sv
module rfpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] floor_stage_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] floor_act_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap_o = tick_i && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o       <= '0;
      floor_act_o <= '0;
    end else if (wrap_o) begin
      cnt_o       <= floor_stage_i;
      floor_act_o <= floor_stage_i;
    end else if (tick_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_above_floor_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_o >= floor_act_o);
  assert_wrap_to_floor_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && cnt_o == CNT_MAX) |=> cnt_o == $past(floor_stage_i));
  assert_hold_count_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(cnt_o));
  assert_floor_staged_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_o |=> $stable(floor_act_o));
endmodule

// File: rtl/rfpwm_channel.sv
module rfpwm_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cmp_stage_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pol_i,
  input  logic             oe_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_act;
  logic             first_state;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cmp_act <= '0;
    else if (wrap_i) cmp_act <= cmp_stage_i;
  end

  assign first_state = (cnt_i <= cmp_act);

  always_ff @(posedge clk_i) begin
    if (rst_i) pwm_o <= 1'b0;
    else       pwm_o <= (oe_i & first_state) ^ pol_i;
  end

  assert_cmp_staged_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(cmp_act));
endmodule

// File: rtl/rfpwm_timer.sv
module rfpwm_timer #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cnt_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  logic                         run;
  logic                         wrap;
  logic                         flag;
  logic [CNT_W-1:0]             floor_stage;
  logic [CNT_W-1:0]             floor_act;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_CH-1:0]            pol;
  logic [NUM_CH-1:0]            oe;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_stage;

  rfpwm_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .wrap_i(wrap),
    .rd_data_o(rd_data_o), .run_o(run), .floor_stage_o(floor_stage),
    .pol_o(pol), .oe_o(oe), .cmp_stage_o(cmp_stage), .flag_o(flag)
  );

  rfpwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(cnt_en_i & run),
    .floor_stage_i(floor_stage), .cnt_o(cnt), .floor_act_o(floor_act),
    .wrap_o(wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rfpwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i(clk_i), .rst_i(rst_i), .wrap_i(wrap),
      .cmp_stage_i(cmp_stage[c]), .cnt_i(cnt), .pol_i(pol[c]),
      .oe_i(oe[c]), .pwm_o(pwm_o[c])
    );
  end

  assign irq_o = flag;

  assert_irq_after_wrap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap |=> irq_o);
  assert_floor_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    floor_act <= cnt);
endmodule

// File: tb/test_rfpwm_timer.sv
module test_rfpwm_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       cnt_en;
  logic       wr_en;
  logic       rd_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] pwm;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  rfpwm_timer i_rfpwm_timer (
    .clk_i(clk), .rst_i(rst), .cnt_en_i(cnt_en), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic wait_lvl(input int ch, input logic lvl);
    int g = 0;
    while (pwm[ch] != lvl && g < 3000) begin @(negedge clk); g++; end
  endtask

  // One full high run followed by the low run after it.
  task automatic cycle_runs(input int ch, output int hi, output int lo);
    @(negedge clk);
    wait_lvl(ch, 1'b0);
    wait_lvl(ch, 1'b1);
    hi = 0; lo = 0;
    while (pwm[ch] == 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    while (pwm[ch] == 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
  endtask

  task automatic hold_check(input int ch, input logic lvl, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch] != lvl) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    int d;
    check("R10 pwm after reset", int'(pwm), 0);
    check("R10 irq after reset", int'(irq), 0);
    rd(0, d); check("R10 ctrl reset", d, 0);
    rd(1, d); check("R10 floor reset", d, 0);
    rd(4, d); check("R10 cmp0 reset", d, 0);
  endtask

  task automatic t_setup;
    int d;
    wr(1, 6); wr(4, 100); wr(5, 3); wr(6, 255); wr(7, 100);
    wr(2, 8'h08); wr(3, 8'h0F); wr(0, 1);
    rd(1, d); check("R11 floor readback", d, 6);
    rd(2, d); check("R11 polarity readback", d, 8);
    rd(5, d); check("R11 cmp1 readback", d, 3);
  endtask

  task automatic t_main;
    int hi, lo;
    cycle_runs(0, hi, lo);
    check("R2 first segment floor6 cmp100", hi, 95);
    check("R2 second segment floor6 cmp100", lo, 155);
    check("R1 period floor6", hi + lo, 250);
  endtask

  task automatic t_limits;
    hold_check(1, 1'b0, 300, "R3 cmp below floor stays second state");
    hold_check(2, 1'b1, 300, "R3 cmp 255 stays first state");
  endtask

  task automatic t_polarity;
    int hi, lo;
    cycle_runs(3, hi, lo);
    check("R6 inverted ch3 high run", hi, 155);
    check("R6 inverted ch3 low run", lo, 95);
  endtask

  task automatic t_disable;
    wr(3, 8'h06);
    hold_check(3, 1'b1, 300, "R7 disabled ch3 idles at pol=1");
    hold_check(0, 1'b0, 300, "R7 disabled ch0 idles at pol=0");
    wr(3, 8'h0F);
  endtask

  task automatic t_stage_cmp;
    int lo, hi, g;
    @(negedge clk);
    wait_lvl(0, 1'b1);
    wait_lvl(0, 1'b0);
    wr_en = 1'b1; addr = 4'd4; wdata = 8'd200;
    lo = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm[0] == 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
    check("R4 running period keeps old compare", lo, 155);
    hi = 0; g = 0;
    while (pwm[0] == 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    check("R4 next period uses new compare", hi, 195);
  endtask

  task automatic t_floor;
    int hi, lo;
    wr(1, 56);
    cycle_runs(0, hi, lo);
    check("R5 first segment floor56 cmp200", hi, 145);
    check("R1 period floor56", hi + lo, 200);
  endtask

  task automatic t_flag;
    int d;
    @(negedge clk);
    wait_lvl(0, 1'b0);
    wait_lvl(0, 1'b1);
    check("R8 irq after restart", int'(irq), 1);
    rd(0, d); check("R8 flag bit7 read", (d >> 7) & 1, 1);
    rd(0, d); check("R8 flag cleared by read", (d >> 7) & 1, 0);
    check("R8 irq cleared", int'(irq), 0);
  endtask

  task automatic t_gate;
    int d, hi, lo;
    @(negedge clk);
    wait_lvl(0, 1'b0);
    wait_lvl(0, 1'b1);
    cnt_en = 1'b0;
    rd(0, d);
    hold_check(0, 1'b1, 400, "R9 cnt_en low freezes output");
    check("R9 no restart while cnt_en low", int'(irq), 0);
    cnt_en = 1'b1;
    wait_lvl(0, 1'b0);
    wait_lvl(0, 1'b1);
    wr(0, 0);
    rd(0, d);
    hold_check(0, 1'b1, 400, "R9 run bit 0 freezes output");
    check("R9 no restart while stopped", int'(irq), 0);
    wr(0, 1);
    cycle_runs(0, hi, lo);
    check("R9 period after resume", hi + lo, 200);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; cnt_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_setup();
    t_main();
    t_limits();
    t_polarity();
    t_disable();
    t_stage_cmp();
    t_floor();
    t_flag();
    t_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule